// File: doc/BRIEF.md
# Keyboard/Mouse Bus Device-Side Transmitter

This block is the sending half of a keyboard or mouse on a two-wire open-collector serial bus. The device generates the bus clock. The host can hold the clock line low at any moment to stop the device. A producer hands over one chunk of one to three bytes, for example a make code, a break code or a movement packet. The block sends the bytes in order as 11-bit frames. It drives the lines only through pull-low enables and watches the sampled line levels to detect the host.

If the host pulls the clock low while a byte is partly sent, the whole chunk is sent again from its first byte once the bus is free, not only the broken byte. An inhibit that comes before the first falling clock edge of a byte, or after its last one, loses nothing. All phase lengths are derived from a system-clock frequency parameter. The defaults are 40 µs clock phases, data that moves 20 µs after the clock is released, and a 50 µs quiet period before each byte.

Top module: `ps2_dev_tx`

## Requirements
- R1: `chunk_ready` is high only while the block is idle. A cycle with `chunk_valid` and `chunk_ready` both high loads a chunk: byte 0 in `chunk_data[7:0]`, byte 1 in `[15:8]`, byte 2 in `[23:16]`, and `chunk_len` gives the byte count. A length of 0 is treated as 1. `chunk_valid` while the block is busy has no effect.
- R2: A byte starts only after the synchronised clock and data lines have both been high without a break for the quiet time (50 µs). The start bit is then driven one setup time (20 µs) later.
- R3: Each byte goes out as 11 bits in this order: a start bit of 0, eight data bits LSB first, an odd-parity bit, and a stop bit of 1. The data line changes only while the device has the clock released.
- R4: The clock is held low for 40 µs per bit and released for 40 µs. Data changes 20 µs after the clock is released and 20 µs before it is pulled low again, and it is stable across the falling edge.
- R5: If the clock line reads low during a released phase of bits 1 to 10, the transfer aborts and both lines are released. The chunk is then resent starting from its first byte, after the quiet time.
- R6: If the clock line reads low during the released phase of bit 0 (before the first falling edge), only the current byte is retried. Bytes of the chunk already delivered are not sent again.
- R7: An inhibit after the 11th falling edge of a byte causes no retransmission. The next byte or chunk waits until the bus has been quiet for the quiet time after release.
- R8: `chunk_done` is a single-cycle pulse when the last byte's final low phase ends, and `chunk_ready` is high from that same cycle.
- R9: `ps2_clk_oe` and `ps2_dat_oe` are pull-low enables (1 = pull the line low). Both are 0 during reset and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chunk_valid | input | 1 | Chunk offered |
| chunk_ready | output | 1 | Block idle, chunk accepted this cycle if valid |
| chunk_data | input | 8*MAX_BYTES | Chunk bytes, byte 0 lowest |
| chunk_len | input | clog2(MAX_BYTES+1) | Number of bytes in chunk |
| ps2_clk_in | input | 1 | Sampled level of the bus clock line |
| ps2_dat_in | input | 1 | Sampled level of the bus data line |
| ps2_clk_oe | output | 1 | Pull clock line low |
| ps2_dat_oe | output | 1 | Pull data line low |
| chunk_done | output | 1 | Pulse when the whole chunk has been sent |

## Verification
The assertions check four things on every cycle: data moves only while the clock is released, data is stable when the clock is pulled low, the lines are released whenever the block is idle or has just aborted, and a start bit appears only while the quiet-bus condition holds. Three behaviours can only be shown by the bench scenarios, because they span many phases and depend on when the host acts: the exact phase widths, whether a chunk is resent in full or only from the current byte, and the length of the quiet gap after the host releases the clock. A scoreboard compares every decoded frame with the byte stream that the requirements predict.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HI   = 2'd2,
        ST_LO   = 2'd3
    } tx_state_e;

    // start + 8 data + parity + stop
    localparam int FRAME_BITS = 11;

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ps2tx_bus_watch.sv
module ps2tx_bus_watch #(
    parameter int QUIET_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_s,
    input  logic dat_s,
    output logic free_o
);

    localparam int CNT_W = $clog2(QUIET_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUIET_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!(clk_s && dat_s))   cnt_d = '0;
        else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign free_o = (cnt_q == CNT_TOP);

    // R2: quiet verdict only follows cycles in which both lines were high
    p_free_after_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |-> ($past(clk_s) && $past(dat_s)));

endmodule

// File: rtl/ps2tx_frame_bit.sv
module ps2tx_frame_bit (
    input  logic [7:0] byte_i,
    input  logic [3:0] idx_i,
    output logic       bit_o
);

    logic par_odd;

    always_comb begin
        par_odd = ~^byte_i;
        case (idx_i)
            4'd0:    bit_o = 1'b0;
            4'd9:    bit_o = par_odd;
            4'd10:   bit_o = 1'b1;
            default: bit_o = (idx_i >= 4'd1 && idx_i <= 4'd8) ? byte_i[3'(idx_i - 4'd1)] : 1'b1;
        endcase
    end

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int HALF_US   = 40,
    parameter int SETUP_US  = 20,
    parameter int QUIET_US  = 50,
    parameter int GUARD_CYC = 4,
    parameter int MAX_BYTES = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               chunk_valid,
    output logic                               chunk_ready,
    input  logic [8*MAX_BYTES-1:0]             chunk_data,
    input  logic [$clog2(MAX_BYTES+1)-1:0]     chunk_len,
    input  logic                               ps2_clk_in,
    input  logic                               ps2_dat_in,
    output logic                               ps2_clk_oe,
    output logic                               ps2_dat_oe,
    output logic                               chunk_done
);
    import ps2tx_pkg::*;

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int HALF_CYC   = HALF_US * CYC_PER_US;
    localparam int SETUP_CYC  = SETUP_US * CYC_PER_US;
    localparam int QUIET_CYC  = QUIET_US * CYC_PER_US;
    localparam int TMR_W      = $clog2(HALF_CYC + 1);
    localparam int LEN_W      = $clog2(MAX_BYTES + 1);
    localparam int CHUNK_W    = 8 * MAX_BYTES;

    localparam logic [TMR_W-1:0] T_LAST  = TMR_W'(HALF_CYC - 1);
    localparam logic [TMR_W-1:0] T_MOVE  = TMR_W'(HALF_CYC - SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] T_GUARD = TMR_W'(GUARD_CYC);
    localparam logic [3:0]       B_LAST  = 4'(FRAME_BITS - 1);
    localparam logic [LEN_W-1:0] L_MAX   = LEN_W'(MAX_BYTES);

    typedef struct packed {
        tx_state_e          st;
        logic [TMR_W-1:0]   tmr;
        logic [3:0]         bit_idx;
        logic [LEN_W-1:0]   byte_idx;
        logic [LEN_W-1:0]   len;
        logic [CHUNK_W-1:0] data;
        logic               clk_oe;
        logic               dat_oe;
        logic               done;
    } tx_regs_t;

    tx_regs_t r_q, r_d;

    logic [1:0] lines_s;
    logic       clk_s, dat_s;
    logic       bus_free;
    logic [7:0] cur_byte;
    logic       cur_bit;
    logic       abort;

    ps2tx_sync #(.LINES(2), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ps2_dat_in, ps2_clk_in}),
        .sync_o  (lines_s)
    );
    assign clk_s = lines_s[0];
    assign dat_s = lines_s[1];

    ps2tx_bus_watch #(.QUIET_CYC(QUIET_CYC)) i_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_s  (clk_s),
        .dat_s  (dat_s),
        .free_o (bus_free)
    );

    assign cur_byte = r_q.data[8*r_q.byte_idx +: 8];

    ps2tx_frame_bit i_frame (
        .byte_i (cur_byte),
        .idx_i  (r_q.bit_idx),
        .bit_o  (cur_bit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        abort    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (chunk_valid) begin
                    r_d.st       = ST_WAIT;
                    r_d.data     = chunk_data;
                    r_d.byte_idx = '0;
                    if (chunk_len == '0)        r_d.len = LEN_W'(1);
                    else if (chunk_len > L_MAX) r_d.len = L_MAX;
                    else                        r_d.len = chunk_len;
                end
            end
            ST_WAIT: begin
                if (bus_free) begin
                    r_d.st      = ST_HI;
                    r_d.tmr     = '0;
                    r_d.bit_idx = '0;
                end
            end
            ST_HI: begin
                if (r_q.tmr >= T_GUARD && !clk_s) begin
                    // host holds clock low while it should be high
                    abort       = 1'b1;
                    r_d.st      = ST_WAIT;
                    r_d.tmr     = '0;
                    r_d.dat_oe  = 1'b0;
                    r_d.clk_oe  = 1'b0;
                    r_d.bit_idx = '0;
                    if (r_q.bit_idx != 4'd0) r_d.byte_idx = '0;
                end else begin
                    if (r_q.tmr == T_MOVE) r_d.dat_oe = ~cur_bit;
                    if (r_q.tmr == T_LAST) begin
                        r_d.st     = ST_LO;
                        r_d.tmr    = '0;
                        r_d.clk_oe = 1'b1;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end
            end
            ST_LO: begin
                if (r_q.tmr == T_LAST) begin
                    r_d.clk_oe = 1'b0;
                    r_d.tmr    = '0;
                    if (r_q.bit_idx == B_LAST) begin
                        r_d.dat_oe  = 1'b0;
                        r_d.bit_idx = '0;
                        if (r_q.byte_idx == LEN_W'(r_q.len - 1'b1)) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.byte_idx = r_q.byte_idx + 1'b1;
                            r_d.st       = ST_WAIT;
                        end
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.st      = ST_HI;
                    end
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign chunk_ready = (r_q.st == ST_IDLE);
    assign ps2_clk_oe  = r_q.clk_oe;
    assign ps2_dat_oe  = r_q.dat_oe;
    assign chunk_done  = r_q.done;

    // R3: data line moves only across a released clock
    p_data_moves_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ps2_dat_oe != $past(ps2_dat_oe)) |-> (!ps2_clk_oe && !$past(ps2_clk_oe)));

    // R4: data steady when the clock is pulled low
    p_data_steady_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps2_clk_oe) |-> $stable(ps2_dat_oe));

    // R9: idle means both lines released
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_ready |-> (!ps2_clk_oe && !ps2_dat_oe));

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |=> !chunk_done);

    // R5: an abort releases both lines and keeps the chunk
    p_abort_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!ps2_clk_oe && !ps2_dat_oe && !chunk_ready));

    // R2: a start bit appears only while the bus counts as quiet
    p_start_after_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ps2_dat_oe) && r_q.bit_idx == 4'd0) |-> bus_free);

endmodule

// File: tb/test_ps2_dev_tx.sv
module test_ps2_dev_tx;

    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ     = 1_000_000;
    localparam int HALF       = 40;
    localparam int SETUP      = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chunk_valid = 1'b0;
    logic [23:0] chunk_data = '0;
    logic [1:0]  chunk_len = '0;
    logic        host_inh = 1'b0;
    logic        chunk_ready, clk_oe, dat_oe, chunk_done;
    logic        bus_clk, bus_dat;

    assign bus_clk = ~(clk_oe | host_inh);
    assign bus_dat = ~dat_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_dev_tx #(.CLK_HZ(SYS_HZ)) i_ps2_dev_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .chunk_valid (chunk_valid),
        .chunk_ready (chunk_ready),
        .chunk_data  (chunk_data),
        .chunk_len   (chunk_len),
        .ps2_clk_in  (bus_clk),
        .ps2_dat_in  (bus_dat),
        .ps2_clk_oe  (clk_oe),
        .ps2_dat_oe  (dat_oe),
        .chunk_done  (chunk_done)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [7:0]  exp_q[$];
    string       cur_req = "R3";
    int          mon_bits = 0;
    int          mon_bytes = 0;
    int          done_cnt = 0;
    logic [10:0] mon_shift = '0;
    logic        prev_clk_oe = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: decodes frames at device-made falling edges, scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (chunk_done) done_cnt++;
            if (host_inh) begin
                mon_bits = 0;
            end else if (clk_oe && !prev_clk_oe) begin
                mon_shift[mon_bits] = bus_dat;
                mon_bits++;
                if (mon_bits == 11) begin
                    chk(mon_shift[0] == 1'b0, "R3", "start bit", mon_shift[0], 0);
                    chk(mon_shift[10] == 1'b1, "R3", "stop bit", mon_shift[10], 1);
                    chk(^mon_shift[9:1] == 1'b1, "R3", "odd parity", mon_shift[9], ~^mon_shift[8:1]);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, cur_req, "unexpected byte", mon_shift[8:1], 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(mon_shift[8:1] == e, cur_req, "byte", mon_shift[8:1], e);
                    end
                    mon_bits = 0;
                    mon_bytes++;
                end
            end
            prev_clk_oe = clk_oe;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] len, input logic [23:0] data);
        while (!chunk_ready) @(negedge clk);
        chunk_valid = 1'b1;
        chunk_len   = len;
        chunk_data  = data;
        @(negedge clk);
        chunk_valid = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic run_all();
        int n;
        int base;
        int d0;

        // reset state
        cyc(3);
        chk(chunk_ready == 1'b1, "R1", "ready after reset", chunk_ready, 1);
        chk(clk_oe == 1'b0, "R9", "clk_oe after reset", clk_oe, 0);
        chk(dat_oe == 1'b0, "R9", "dat_oe after reset", dat_oe, 0);
        chk(chunk_done == 1'b0, "R8", "done after reset", chunk_done, 0);
        rst_n = 1'b1;
        cyc(80);

        // R4 phase timing on 0x55
        cur_req = "R4";
        push(8'h55);
        send(2'd1, 24'h000055);
        while (!dat_oe) @(negedge clk);
        n = 0;
        while (!clk_oe) begin @(negedge clk); n++; end
        chk(n == SETUP, "R4", "start setup cycles", n, SETUP);
        n = 0;
        while (clk_oe) begin @(negedge clk); n++; end
        chk(n == HALF, "R4", "clock low cycles", n, HALF);
        n = 0;
        while (dat_oe) begin @(negedge clk); n++; end
        chk(n == SETUP, "R4", "data move after release", n, SETUP);
        n = 0;
        while (!clk_oe) begin @(negedge clk); n++; end
        chk(n == SETUP, "R4", "data setup before fall", n, SETUP);
        while (!chunk_done) @(negedge clk);
        @(negedge clk);
        chk(chunk_done == 1'b0, "R8", "done width", chunk_done, 0);
        chk(chunk_ready == 1'b1, "R8", "ready after done", chunk_ready, 1);
        chk(exp_q.size() == 0, "R4", "pending bytes", exp_q.size(), 0);

        // R3 frame patterns, R1 lengths
        cur_req = "R3";
        push(8'h00); push(8'hFF); push(8'h81);
        send(2'd3, 24'h81FF00);
        wait_done(2);
        cur_req = "R1";
        push(8'h01); push(8'h7E);
        send(2'd2, 24'h997E01);
        wait_done(3);
        push(8'hB4);
        send(2'd0, 24'h3322B4);
        wait_done(4);
        chk(exp_q.size() == 0, "R1", "pending bytes after lengths", exp_q.size(), 0);

        // R1 valid while busy is ignored
        base = mon_bytes;
        push(8'h66);
        send(2'd1, 24'h000066);
        while (!clk_oe) @(negedge clk);
        chk(chunk_ready == 1'b0, "R1", "ready while busy", chunk_ready, 0);
        chunk_valid = 1'b1; chunk_len = 2'd1; chunk_data = 24'h0000EE;
        @(negedge clk);
        chunk_valid = 1'b0;
        wait_done(5);
        cyc(300);
        chk(mon_bytes == base + 1, "R1", "bytes after busy valid", mon_bytes, base + 1);
        chk(clk_oe == 1'b0, "R1", "no activity after busy valid", clk_oe, 0);

        // R5 mid-byte abort resends whole chunk
        cur_req = "R5";
        base = mon_bytes;
        push(8'h11); push(8'h11); push(8'h22); push(8'h33);
        send(2'd3, 24'h332211);
        wait (mon_bytes == base + 1 && mon_bits == 5);
        @(negedge clk);
        host_inh = 1'b1;
        cyc(60);
        chk(clk_oe == 1'b0, "R5", "clk released in inhibit", clk_oe, 0);
        chk(dat_oe == 1'b0, "R5", "dat released in inhibit", dat_oe, 0);
        cyc(60);
        host_inh = 1'b0;
        wait_done(6);
        chk(exp_q.size() == 0, "R5", "pending bytes after resend", exp_q.size(), 0);
        chk(mon_bytes == base + 4, "R5", "bytes after resend", mon_bytes, base + 4);

        // R6 abort in bit 0 retries only the current byte
        cur_req = "R6";
        base = mon_bytes;
        push(8'h44); push(8'h99);
        send(2'd2, 24'h009944);
        wait (mon_bytes == base + 1);
        while (!dat_oe) @(negedge clk);
        host_inh = 1'b1;
        cyc(120);
        chk(dat_oe == 1'b0, "R6", "dat released", dat_oe, 0);
        host_inh = 1'b0;
        wait_done(7);
        chk(mon_bytes == base + 2, "R6", "bytes after bit-0 abort", mon_bytes, base + 2);
        chk(exp_q.size() == 0, "R6", "pending bytes", exp_q.size(), 0);

        // R7 inhibit after last falling edge: no resend, quiet gap honoured
        cur_req = "R7";
        base = mon_bytes;
        push(8'hA5); push(8'h3C);
        send(2'd2, 24'h003CA5);
        wait (mon_bytes == base + 1);
        @(negedge clk);
        host_inh = 1'b1;
        cyc(150);
        chk(dat_oe == 1'b0, "R7", "no start while inhibited", dat_oe, 0);
        host_inh = 1'b0;
        d0 = 0;
        while (!dat_oe) begin @(negedge clk); d0++; end
        chk(d0 >= 70 && d0 <= 76, "R2", "release to start bit", d0, 73);
        wait_done(8);
        chk(mon_bytes == base + 2, "R7", "bytes after late inhibit", mon_bytes, base + 2);
        chk(exp_q.size() == 0, "R7", "pending bytes", exp_q.size(), 0);
        chk(done_cnt == 8, "R8", "done pulse count", done_cnt, 8);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule